// File: doc/BRIEF.md
# Multimode Asynchronous Serial Receiver

This block receives asynchronous serial frames for a small controller-style serial port. It handles three framed modes: one with a 10-bit frame (start, eight data bits, stop) and two with an 11-bit frame (start, eight data bits, a ninth bit, stop). The mode inputs select the frame length and where bit timing comes from. Timing is taken either from an external baud tick or straight from the system clock, and a speed input picks a long or a short bit period.

The line passes through a synchronizer. A falling edge arms the receiver, and the start bit is confirmed at its midpoint. Each later bit is sampled once, in the middle of its period, least significant data bit first. At the end of a frame the result is either accepted or dropped. A filter input controls this choice. In the 10-bit mode it discards frames whose stop bit is wrong. In the 11-bit modes it discards frames whose ninth bit is 0, which serves address filtering on a shared line. The receive flag and the framing-error flag are sticky, and each is cleared by its own strobe.

Top module: `mm_serial_rx`

## Requirements
- R1: Mode select {sm1,sm0}: 2'b10 receives 10-bit frames timed by baud_tick; 2'b11 receives 11-bit frames timed by baud_tick; 2'b01 receives 11-bit frames timed by the system clock; 2'b00 receives nothing.
- R2: With smod=0 a bit lasts 64 timing ticks. With smod=1 a bit lasts 16 baud ticks in the baud-timed modes and 32 system clocks in the clock-timed mode.
- R3: Data bits are taken least significant first, each sampled at the middle of its bit. An accepted frame loads rx_data.
- R4: A low pulse on rxd shorter than half a bit is rejected at the mid-start check and produces no frame.
- R5: In the 11-bit modes rb8 takes the received ninth bit. In the 10-bit mode with sm2=0 it takes the stop-bit level. In the 10-bit mode with sm2=1 it is left unchanged.
- R6: A stop bit sampled low sets fe. fe then stays set through later good frames and clears only on fe_clr. A set in the same cycle as fe_clr wins.
- R7: In the 10-bit mode with sm2=1, a frame with a low stop bit leaves ri, rx_data and rb8 unchanged.
- R8: In the 11-bit modes with sm2=1, a frame whose ninth bit is 0 leaves ri, rx_data and rb8 unchanged.
- R9: An accepted frame sets ri. ri stays set until ri_clr, and a set in the same cycle as ri_clr wins.
- R10: While ren=0 no frame starts. Dropping ren during a frame aborts that frame without setting any flag.
- R11: After reset rx_data=8'h00 and rb8, ri and fe are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Asynchronous serial line, idle high |
| baud_tick | input | 1 | One-cycle timing pulse for the baud-timed modes |
| sm2 | input | 1 | Frame filter enable |
| sm1 | input | 1 | Mode select, upper bit |
| sm0 | input | 1 | Mode select, lower bit |
| smod | input | 1 | Short bit period select |
| ren | input | 1 | Receive enable |
| ri_clr | input | 1 | Strobe that clears ri |
| fe_clr | input | 1 | Strobe that clears fe |
| rx_data | output | 8 | Last accepted data byte |
| rb8 | output | 1 | Ninth bit or stop bit of the last accepted frame |
| ri | output | 1 | Sticky receive flag |
| fe | output | 1 | Sticky framing-error flag |

## Verification
A vector table drives frames in every framed mode at both speeds, with the filter both on and off, good and bad stop bits, and ninth bits of both values. Distinct data bytes such as A5, 81 and 0F reveal bit reversal or a slip of one bit. Running both speeds separates a wrong period choice from correct sampling. The filtered cases set apart an ignored frame (flags and data unchanged) from an accepted one, and a bad stop bit in the 10-bit mode with the filter off sets apart framing-error reporting from discarding. Directed cases then cover a short glitch, a disabled receiver, an aborted frame, the disabled mode 00, and both clear strobes.

// File: rtl/mmrx_pkg.sv
package mmrx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_NINTH = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

  typedef struct packed {
    logic [7:0] data;
    logic       ninth;
    logic       stop;
    logic       long_frame;
  } rx_result_t;
endpackage

// File: rtl/mmrx_sync.sv
module mmrx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/mmrx_bitclk.sv
module mmrx_bitclk #(
  parameter int LONG_DIV       = 64,
  parameter int SHORT_BAUD_DIV = 16,
  parameter int SHORT_SYS_DIV  = 32,
  parameter int CNT_W          = $clog2(LONG_DIV)
) (
  input  logic             baud_tick,
  input  logic             sm1,
  input  logic             sm0,
  input  logic             smod,
  output logic             tick,
  output logic             active,
  output logic             long_frame,
  output logic [CNT_W-1:0] period_m1,
  output logic [CNT_W-1:0] half_m1
);
  localparam logic [CNT_W-1:0] L_PER  = CNT_W'(LONG_DIV - 1);
  localparam logic [CNT_W-1:0] L_HALF = CNT_W'(LONG_DIV / 2 - 1);
  localparam logic [CNT_W-1:0] B_PER  = CNT_W'(SHORT_BAUD_DIV - 1);
  localparam logic [CNT_W-1:0] B_HALF = CNT_W'(SHORT_BAUD_DIV / 2 - 1);
  localparam logic [CNT_W-1:0] S_PER  = CNT_W'(SHORT_SYS_DIV - 1);
  localparam logic [CNT_W-1:0] S_HALF = CNT_W'(SHORT_SYS_DIV / 2 - 1);

  logic sys_timed;

  always_comb begin
    sys_timed  = ~sm1 & sm0;
    active     = sm1 | sm0;
    long_frame = sm0;
    tick       = sys_timed ? 1'b1 : baud_tick;
    if (!smod) begin
      period_m1 = L_PER;
      half_m1   = L_HALF;
    end else if (sys_timed) begin
      period_m1 = S_PER;
      half_m1   = S_HALF;
    end else begin
      period_m1 = B_PER;
      half_m1   = B_HALF;
    end
  end
endmodule

// File: rtl/mmrx_frame.sv
module mmrx_frame
  import mmrx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line,
  input  logic             tick,
  input  logic             ren,
  input  logic             active,
  input  logic             long_frame,
  input  logic [CNT_W-1:0] period_m1,
  input  logic [CNT_W-1:0] half_m1,
  output logic             done,
  output rx_result_t       result
);
  localparam int BIT_W = $clog2(DATA_W);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitn;
  logic [DATA_W-1:0] shreg;
  logic              ninth_q;
  logic              stop_q;
  logic              long_q;
  logic              line_q;
  logic              fall;
  logic              sample;

  assign fall   = line_q & ~line;
  assign sample = tick && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      shreg   <= '0;
      ninth_q <= 1'b0;
      stop_q  <= 1'b1;
      long_q  <= 1'b0;
      line_q  <= 1'b1;
      done    <= 1'b0;
    end else begin
      done   <= 1'b0;
      line_q <= line;
      if (!ren || !active) begin
        state <= ST_IDLE;
      end else if (state == ST_IDLE) begin
        if (fall) begin
          state <= ST_START;
          cnt   <= half_m1;
        end
      end else if (tick) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else begin
          cnt <= period_m1;
          case (state)
            ST_START: begin
              if (line) state <= ST_IDLE;
              else begin
                state <= ST_DATA;
                bitn  <= '0;
              end
            end
            ST_DATA: begin
              shreg <= {line, shreg[DATA_W-1:1]};
              if (bitn == BIT_W'(DATA_W - 1))
                state <= long_frame ? ST_NINTH : ST_STOP;
              else
                bitn <= bitn + 1'b1;
            end
            ST_NINTH: begin
              ninth_q <= line;
              state   <= ST_STOP;
            end
            ST_STOP: begin
              stop_q <= line;
              long_q <= long_frame;
              done   <= 1'b1;
              state  <= ST_IDLE;
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign result.data       = shreg;
  assign result.ninth      = ninth_q;
  assign result.stop       = stop_q;
  assign result.long_frame = long_q;

  // R10: with the receiver disabled the machine never leaves idle
  a_r10_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !ren) |=> (state == ST_IDLE));

  // R4: a start bit found high at its midpoint returns to idle
  a_r4_glitch_reject: assert property (@(posedge clk) disable iff (rst)
    (state == ST_START && sample && line && ren && active) |=> (state == ST_IDLE));

  // R10: a frame is only completed while enabled
  a_r10_done_needs_ren: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(ren));
endmodule

// File: rtl/mmrx_flags.sv
module mmrx_flags
  import mmrx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  rx_result_t        result,
  input  logic              sm2,
  input  logic              ri_clr,
  input  logic              fe_clr,
  output logic              accept,
  output logic [DATA_W-1:0] rx_data,
  output logic              rb8,
  output logic              ri,
  output logic              fe
);
  logic pass_filter;
  logic bad_stop;

  always_comb begin
    bad_stop = done && !result.stop;
    if (result.long_frame) pass_filter = !sm2 || result.ninth;
    else                   pass_filter = !sm2 || result.stop;
    accept = done && pass_filter;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      rb8     <= 1'b0;
      ri      <= 1'b0;
      fe      <= 1'b0;
    end else begin
      if (bad_stop)    fe <= 1'b1;
      else if (fe_clr) fe <= 1'b0;
      if (accept)      ri <= 1'b1;
      else if (ri_clr) ri <= 1'b0;
      if (accept) begin
        rx_data <= result.data;
        if (result.long_frame) rb8 <= result.ninth;
        else if (!sm2)         rb8 <= result.stop;
      end
    end
  end

  // R6: framing error remains until its clear strobe
  a_r6_fe_sticky: assert property (@(posedge clk) disable iff (rst)
    (fe && !fe_clr) |=> fe);

  // R9: receive flag remains until its clear strobe
  a_r9_ri_sticky: assert property (@(posedge clk) disable iff (rst)
    (ri && !ri_clr) |=> ri);
endmodule

// File: rtl/mm_serial_rx.sv
module mm_serial_rx
  import mmrx_pkg::*;
#(
  parameter int DATA_W         = 8,
  parameter int SYNC_STAGES    = 2,
  parameter int LONG_DIV       = 64,
  parameter int SHORT_BAUD_DIV = 16,
  parameter int SHORT_SYS_DIV  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxd,
  input  logic              baud_tick,
  input  logic              sm2,
  input  logic              sm1,
  input  logic              sm0,
  input  logic              smod,
  input  logic              ren,
  input  logic              ri_clr,
  input  logic              fe_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rb8,
  output logic              ri,
  output logic              fe
);
  localparam int CNT_W = $clog2(LONG_DIV);

  logic             line;
  logic             tick;
  logic             active;
  logic             long_frame;
  logic [CNT_W-1:0] period_m1;
  logic [CNT_W-1:0] half_m1;
  logic             done;
  logic             accept;
  rx_result_t       result;

  mmrx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(line)
  );

  mmrx_bitclk #(
    .LONG_DIV(LONG_DIV), .SHORT_BAUD_DIV(SHORT_BAUD_DIV),
    .SHORT_SYS_DIV(SHORT_SYS_DIV), .CNT_W(CNT_W)
  ) i_bitclk (
    .baud_tick(baud_tick), .sm1(sm1), .sm0(sm0), .smod(smod),
    .tick(tick), .active(active), .long_frame(long_frame),
    .period_m1(period_m1), .half_m1(half_m1)
  );

  mmrx_frame #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_frame (
    .clk(clk), .rst(rst), .line(line), .tick(tick), .ren(ren),
    .active(active), .long_frame(long_frame), .period_m1(period_m1),
    .half_m1(half_m1), .done(done), .result(result)
  );

  mmrx_flags #(.DATA_W(DATA_W)) i_flags (
    .clk(clk), .rst(rst), .done(done), .result(result), .sm2(sm2),
    .ri_clr(ri_clr), .fe_clr(fe_clr), .accept(accept),
    .rx_data(rx_data), .rb8(rb8), .ri(ri), .fe(fe)
  );

  // R7 R8: a finished but filtered frame leaves data and ninth-bit flag alone
  a_r7_r8_discard_hold: assert property (@(posedge clk) disable iff (rst)
    (done && !accept) |=> ($stable(rx_data) && $stable(rb8)));

  // R9: ri only rises on a finished frame
  a_r9_ri_rise_on_frame: assert property (@(posedge clk) disable iff (rst)
    $rose(ri) |-> $past(done));

  // R6: fe only rises after a low stop bit
  a_r6_fe_rise_on_bad_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(fe) |-> ($past(done) && !$past(result.stop)));
endmodule

// File: tb/test_mm_serial_rx.sv
module test_mm_serial_rx;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  // fields: [13]sm1 [12]sm0 [11]sm2 [10]smod [9]ninth [8]stop [7:0]data
  localparam logic [13:0] VEC [NVEC] = '{
    {4'b1001, 2'b01, 8'hA5},
    {4'b1000, 2'b01, 8'h3C},
    {4'b1001, 2'b00, 8'h81},
    {4'b1011, 2'b00, 8'h7E},
    {4'b1011, 2'b01, 8'h5A},
    {4'b0100, 2'b11, 8'hC3},
    {4'b0101, 2'b01, 8'h12},
    {4'b0111, 2'b01, 8'h99},
    {4'b1111, 2'b11, 8'h6D},
    {4'b1100, 2'b00, 8'hF0},
    {4'b1111, 2'b01, 8'h0F}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rxd = 1'b1;
  logic baud_tick = 1'b0;
  logic sm2 = 1'b0, sm1 = 1'b0, sm0 = 1'b0, smod = 1'b0, ren = 1'b0;
  logic ri_clr = 1'b0, fe_clr = 1'b0;
  logic [7:0] rx_data;
  logic rb8, ri, fe;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_data = 8'h00;
  logic exp_rb8 = 1'b0, exp_ri = 1'b0, exp_fe = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mm_serial_rx i_mm_serial_rx (
    .clk(clk), .rst(rst), .rxd(rxd), .baud_tick(baud_tick), .sm2(sm2),
    .sm1(sm1), .sm0(sm0), .smod(smod), .ren(ren), .ri_clr(ri_clr),
    .fe_clr(fe_clr), .rx_data(rx_data), .rb8(rb8), .ri(ri), .fe(fe)
  );

  initial begin
    forever begin
      @(negedge clk) baud_tick = 1'b1;
      @(negedge clk) baud_tick = 1'b0;
    end
  end

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int bit_clks();
    if (!sm1 && sm0) return smod ? 32 : 64;
    return (smod ? 16 : 64) * 2;
  endfunction

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic nb, input logic sb);
    int per = bit_clks();
    rxd = 1'b0; hold(per);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; hold(per); end
    if (sm0) begin rxd = nb; hold(per); end
    rxd = sb; hold(per);
    rxd = 1'b1; hold(per + 8);
  endtask

  task automatic model_frame(input logic [7:0] d, input logic nb, input logic sb);
    logic acc;
    if (!sb) exp_fe = 1'b1;
    acc = sm0 ? (!sm2 || nb) : (!sm2 || sb);
    if (acc) begin
      exp_data = d;
      exp_ri   = 1'b1;
      if (sm0) exp_rb8 = nb;
      else if (!sm2) exp_rb8 = sb;
    end
  endtask

  task automatic check_all(input string req);
    check({req, " rx_data"}, rx_data, exp_data);
    check({req, " rb8"}, rb8, exp_rb8);
    check({req, " ri"}, ri, exp_ri);
    check({req, " fe"}, fe, exp_fe);
  endtask

  task automatic pulse_ri_clr();
    ri_clr = 1'b1; hold(1); ri_clr = 1'b0; hold(1);
    exp_ri = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    hold(5);
    rst = 1'b0;
    hold(2);
    check_all("R11 reset");

    ren = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      {sm1, sm0, sm2, smod} = VEC[v][13:10];
      hold(2);
      pulse_ri_clr();
      send_frame(VEC[v][7:0], VEC[v][9], VEC[v][8]);
      model_frame(VEC[v][7:0], VEC[v][9], VEC[v][8]);
      check_all("R1 R2 R3 R5 R6 R7 R8 R9 vector");
    end

    // R6: clear strobe removes the framing error
    fe_clr = 1'b1; hold(1); fe_clr = 1'b0; hold(1);
    exp_fe = 1'b0;
    check("R6 fe_clr", fe, 0);

    // R9: clear strobe removes ri
    pulse_ri_clr();
    check("R9 ri_clr", ri, 0);

    // R4: short glitch in mode 1 fast
    {sm1, sm0, sm2, smod} = 4'b1001;
    hold(2);
    rxd = 1'b0; hold(4); rxd = 1'b1;
    hold(400);
    check("R4 glitch ri", ri, 0);
    check("R4 glitch data", rx_data, exp_data);

    // R10: receiver disabled for a whole frame
    ren = 1'b0;
    send_frame(8'h44, 1'b1, 1'b1);
    check("R10 disabled ri", ri, 0);
    check("R10 disabled data", rx_data, exp_data);

    // R10: enable dropped during a frame of all-ones data
    ren = 1'b1; hold(2);
    rxd = 1'b0; hold(bit_clks());
    rxd = 1'b1; hold(2 * bit_clks());
    ren = 1'b0; hold(3 * bit_clks());
    ren = 1'b1; hold(8 * bit_clks());
    check("R10 abort ri", ri, 0);
    check("R10 abort fe", fe, 0);

    // R1: mode 00 receives nothing
    {sm1, sm0, sm2, smod} = 4'b0001;
    hold(2);
    send_frame(8'h22, 1'b1, 1'b1);
    check("R1 mode0 ri", ri, 0);
    check("R1 mode0 data", rx_data, exp_data);

    // R3 R9: a fresh accepted frame after all of the above
    {sm1, sm0, sm2, smod} = 4'b1001;
    hold(2);
    send_frame(8'h96, 1'b0, 1'b1);
    model_frame(8'h96, 1'b0, 1'b1);
    check_all("R3 R9 final");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule